// File: doc/BRIEF.md
# Accumulator ALU with Zero/Negative Flags and Condition Test

This block is the accumulator datapath of a 16-bit signal processor. It holds a 32-bit accumulator and applies subtract, compare, add, AND, OR and XOR to it. The operand is either a 16-bit word, aligned to the upper half of the accumulator, or a full 32-bit value: the multiplier product or the accumulator itself. The caller picks which by the source register index it presents. A short-immediate form takes an 8-bit constant in place of the 16-bit word.

Every arithmetic or logic step leaves behind two status flags, zero and negative, taken from the whole 32-bit result. They are registered in the same clock edge as the accumulator. A condition tester reads these flags and a 4-bit condition field, and tells the sequencer whether a branch, call or conditional modify should happen. Operand fetch, the program counter and the stack are outside the block. The caller supplies the fetched word, the product and a direct accumulator load.

Top module: `acc_alu_unit`

## Requirements
- R1: With `op_valid` high and a 16-bit operand W, code 1 writes A - {W,16'h0} and code 4 writes A + {W,16'h0}, both modulo 2^32. The new value appears on `acc_out` after the clock edge.
- R2: When `short_imm` is low and `src_sel` equals the product index (11), the operand is the whole 32-bit `prod_in`. When it equals the accumulator index (3), the operand is the whole 32-bit accumulator, so AND and OR of A with A leave A unchanged and XOR of A with A gives zero.
- R3: Codes 5, 6 and 7 (AND, OR, XOR) with a 16-bit operand combine W with bits 31:16 of A and leave bits 15:0 of A unchanged.
- R4: Code 3 (compare) sets the flags from A minus the operand and leaves A unchanged.
- R5: With `short_imm` high, the operand is `imm_byte` zero-extended to 16 bits and used as W, and `src_sel` has no effect.
- R6: After any of codes 1, 3, 4, 5, 6, 7, `flag_z` is 1 exactly when the 32-bit result is zero and `flag_n` equals bit 31 of the result. Both flags change at the same edge as the accumulator.
- R7: Codes 0 and 2, or `op_valid` low, leave the accumulator and both flags unchanged.
- R8: Condition field bits 2:0 equal to 0 make `cond_true` high whatever bit 3 holds.
- R9: Condition field bits 2:0 equal to 5 test Z and equal to 7 test N. `cond_true` is high when that flag equals field bit 3. Any other value of bits 2:0 gives `cond_true` low.
- R10: `acc_load` writes `load_val` into A, leaves the flags unchanged and takes priority over an ALU operation in the same cycle.
- R11: A synchronous reset clears A to zero, sets Z to 1 and clears N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the operation on `op_code` this cycle |
| op_code | input | 3 | Operation: 1 sub, 3 cmp, 4 add, 5 and, 6 or, 7 xor |
| src_sel | input | 4 | Source register index (11 product, 3 accumulator, others 16-bit) |
| src_word | input | 16 | Fetched 16-bit operand |
| short_imm | input | 1 | Use `imm_byte` as the operand |
| imm_byte | input | 8 | Low byte of the instruction word |
| prod_in | input | 32 | Multiplier product |
| acc_load | input | 1 | Direct accumulator load |
| load_val | input | 32 | Value for the direct load |
| cond_field | input | 4 | Condition: bits 2:0 select, bit 3 required flag value |
| acc_out | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| cond_true | output | 1 | Condition result |

## Verification
On every cycle, the assertions check the following:
- the flags agree with the accumulator after each writing operation;
- compare, idle cycles and the reserved codes leave the register state alone;
- AND of A with A keeps A;
- a direct load keeps the flags;
- an unconditional field is always true, and reserved selects are always false.

Only the bench's scenarios can show that the arithmetic values are right, including wrap-around. The same holds for upper-word alignment and preservation of the low word, the product path, the short-immediate extension and the polarity of the Z and N tests. The bench shows these by comparing against its own model over random and directed operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    ALU_RSV0 = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_RSV2 = 3'd2,
    ALU_CMP  = 3'd3,
    ALU_ADD  = 3'd4,
    ALU_AND  = 3'd5,
    ALU_OR   = 3'd6,
    ALU_XOR  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
  } alu_flags_t;
endpackage

// File: rtl/acc_operand_align.sv
module acc_operand_align
  import acc_alu_pkg::*;
#(
  parameter int DW     = 16,
  parameter int IMMW   = 8,
  parameter int SW     = 4,
  parameter int SRC_P  = 11,
  parameter int SRC_A  = 3,
  localparam int AW    = 2 * DW
) (
  input  alu_op_e           op,
  input  logic [SW-1:0]     src_sel,
  input  logic [DW-1:0]     src_word,
  input  logic              short_imm,
  input  logic [IMMW-1:0]   imm_byte,
  input  logic [AW-1:0]     prod,
  input  logic [AW-1:0]     acc,
  output logic [AW-1:0]     opnd
);
  logic [DW-1:0] word16;
  logic [DW-1:0] low_fill;
  logic          pick_p;
  logic          pick_a;

  always_comb begin
    word16   = short_imm ? {{(DW-IMMW){1'b0}}, imm_byte} : src_word;
    pick_p   = !short_imm && (src_sel == SW'(SRC_P));
    pick_a   = !short_imm && (src_sel == SW'(SRC_A));
    // AND needs ones below the operand so the low word survives; OR/XOR/add/sub need zeros
    low_fill = (op == ALU_AND) ? {DW{1'b1}} : {DW{1'b0}};
    if (pick_p)      opnd = prod;
    else if (pick_a) opnd = acc;
    else             opnd = {word16, low_fill};
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int AW = 32
) (
  input  alu_op_e         op,
  input  logic [AW-1:0]   acc,
  input  logic [AW-1:0]   opnd,
  output logic [AW-1:0]   result,
  output logic            wr_acc,
  output logic            wr_flags
);
  logic [AW-1:0] diff;

  always_comb begin
    diff     = acc - opnd;
    result   = acc;
    wr_acc   = 1'b0;
    wr_flags = 1'b0;
    unique case (op)
      ALU_SUB: begin result = diff;        wr_acc = 1'b1; wr_flags = 1'b1; end
      ALU_CMP: begin result = diff;                       wr_flags = 1'b1; end
      ALU_ADD: begin result = acc + opnd;  wr_acc = 1'b1; wr_flags = 1'b1; end
      ALU_AND: begin result = acc & opnd;  wr_acc = 1'b1; wr_flags = 1'b1; end
      ALU_OR:  begin result = acc | opnd;  wr_acc = 1'b1; wr_flags = 1'b1; end
      ALU_XOR: begin result = acc ^ opnd;  wr_acc = 1'b1; wr_flags = 1'b1; end
      default: begin result = acc; end
    endcase
  end
endmodule

// File: rtl/acc_cond_eval.sv
module acc_cond_eval
  import acc_alu_pkg::*;
#(
  parameter int CW = 4,
  localparam int SELW = CW - 1
) (
  input  logic [CW-1:0] cond_field,
  input  alu_flags_t    flags,
  output logic          cond_true
);
  localparam logic [SELW-1:0] SEL_ALWAYS = SELW'(0);
  localparam logic [SELW-1:0] SEL_ZERO   = SELW'(5);
  localparam logic [SELW-1:0] SEL_NEG    = SELW'(7);

  logic [SELW-1:0] sel;
  logic            want;

  always_comb begin
    sel  = cond_field[SELW-1:0];
    want = cond_field[CW-1];
    unique case (sel)
      SEL_ALWAYS: cond_true = 1'b1;
      SEL_ZERO:   cond_true = (flags.z == want);
      SEL_NEG:    cond_true = (flags.n == want);
      default:    cond_true = 1'b0;
    endcase
  end

  // R8: unconditional select always passes
  always_comb begin
    if (sel == SEL_ALWAYS) a_r8_always_true: assert (cond_true);
  end

  // R9: reserved selects never pass
  always_comb begin
    if (sel != SEL_ALWAYS && sel != SEL_ZERO && sel != SEL_NEG)
      a_r9_reserved_false: assert (!cond_true);
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IMMW  = 8,
  parameter int SW    = 4,
  parameter int CW    = 4,
  parameter int SRC_P = 11,
  parameter int SRC_A = 3,
  localparam int AW   = 2 * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [SW-1:0]   src_sel,
  input  logic [DW-1:0]   src_word,
  input  logic            short_imm,
  input  logic [IMMW-1:0] imm_byte,
  input  logic [AW-1:0]   prod_in,
  input  logic            acc_load,
  input  logic [AW-1:0]   load_val,
  input  logic [CW-1:0]   cond_field,
  output logic [AW-1:0]   acc_out,
  output logic            flag_z,
  output logic            flag_n,
  output logic            cond_true
);
  alu_op_e       op;
  logic [AW-1:0] acc_q;
  alu_flags_t    flags_q;
  logic [AW-1:0] opnd;
  logic [AW-1:0] result;
  logic          wr_acc;
  logic          wr_flags;

  assign op = alu_op_e'(op_code);

  acc_operand_align #(
    .DW(DW), .IMMW(IMMW), .SW(SW), .SRC_P(SRC_P), .SRC_A(SRC_A)
  ) u_align (
    .op(op), .src_sel(src_sel), .src_word(src_word), .short_imm(short_imm),
    .imm_byte(imm_byte), .prod(prod_in), .acc(acc_q), .opnd(opnd)
  );

  acc_alu_core #(.AW(AW)) u_core (
    .op(op), .acc(acc_q), .opnd(opnd), .result(result),
    .wr_acc(wr_acc), .wr_flags(wr_flags)
  );

  acc_cond_eval #(.CW(CW)) u_cond (
    .cond_field(cond_field), .flags(flags_q), .cond_true(cond_true)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      flags_q.z <= 1'b1;
      flags_q.n <= 1'b0;
    end else if (acc_load) begin
      acc_q <= load_val;
    end else if (op_valid) begin
      if (wr_acc) acc_q <= result;
      if (wr_flags) begin
        flags_q.z <= (result == '0);
        flags_q.n <= result[AW-1];
      end
    end
  end

  assign acc_out = acc_q;
  assign flag_z  = flags_q.z;
  assign flag_n  = flags_q.n;

  logic acc_writing_op;
  assign acc_writing_op = op_valid && !acc_load &&
                          (op == ALU_SUB || op == ALU_ADD || op == ALU_AND ||
                           op == ALU_OR  || op == ALU_XOR);

  // R6: flags match the stored accumulator after a writing operation
  a_r6_zero_tracks_acc: assert property (@(posedge clk) disable iff (rst)
    acc_writing_op |=> (flag_z == (acc_out == '0)));
  a_r6_neg_tracks_acc: assert property (@(posedge clk) disable iff (rst)
    acc_writing_op |=> (flag_n == acc_out[AW-1]));

  // R4: compare never writes the accumulator
  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !acc_load && op == ALU_CMP) |=> $stable(acc_out));

  // R7: idle cycles and reserved codes keep all state
  a_r7_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (!acc_load && (!op_valid || op == ALU_RSV0 || op == ALU_RSV2))
    |=> ($stable(acc_out) && $stable(flag_z) && $stable(flag_n)));

  // R2: AND of the accumulator with itself keeps it
  a_r2_and_self_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !acc_load && !short_imm && op == ALU_AND && src_sel == SW'(SRC_A))
    |=> $stable(acc_out));

  // R10: a direct load leaves the flags alone
  a_r10_load_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> ($stable(flag_z) && $stable(flag_n)));
endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [3:0]  src_sel;
  logic [15:0] src_word;
  logic        short_imm;
  logic [7:0]  imm_byte;
  logic [31:0] prod_in;
  logic        acc_load;
  logic [31:0] load_val;
  logic [3:0]  cond_field;
  logic [31:0] acc_out;
  logic        flag_z, flag_n, cond_true;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] m_acc;
  logic        m_z, m_n;
  bit          done = 0;

  always #2.5 clk = ~clk;

  acc_alu_unit u_acc_alu_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .src_sel(src_sel),
    .src_word(src_word), .short_imm(short_imm), .imm_byte(imm_byte), .prod_in(prod_in),
    .acc_load(acc_load), .load_val(load_val), .cond_field(cond_field),
    .acc_out(acc_out), .flag_z(flag_z), .flag_n(flag_n), .cond_true(cond_true)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string op_req(logic [2:0] op, logic sh, logic [3:0] s);
    if (sh) return "R5";
    if (s == 4'd11 || s == 4'd3) return "R2";
    case (op)
      3'd1, 3'd4: return "R1";
      3'd3: return "R4";
      3'd5, 3'd6, 3'd7: return "R3";
      default: return "R7";
    endcase
  endfunction

  function automatic logic cond_model(logic [3:0] f, logic z, logic n);
    case (f[2:0])
      3'd0: return 1'b1;
      3'd5: return z == f[3];
      3'd7: return n == f[3];
      default: return 1'b0;
    endcase
  endfunction

  // Reference update from the requirements
  task automatic model_op(logic [2:0] op, logic [3:0] s, logic [15:0] w,
                          logic sh, logic [7:0] imm, logic [31:0] p);
    logic [15:0] w16;
    logic [31:0] o, r;
    logic        wr, fl;
    w16 = sh ? {8'h00, imm} : w;
    if (!sh && s == 4'd11)     o = p;
    else if (!sh && s == 4'd3) o = m_acc;
    else                       o = {w16, 16'h0000};
    wr = 1; fl = 1; r = m_acc;
    case (op)
      3'd1: r = m_acc - o;
      3'd3: begin r = m_acc - o; wr = 0; end
      3'd4: r = m_acc + o;
      3'd5: r = (o == {w16, 16'h0000}) && !(!sh && (s == 4'd11 || s == 4'd3))
                ? {m_acc[31:16] & w16, m_acc[15:0]} : m_acc & o;
      3'd6: r = m_acc | o;
      3'd7: r = m_acc ^ o;
      default: begin wr = 0; fl = 0; end
    endcase
    if (fl) begin m_z = (r == 32'h0); m_n = r[31]; end
    if (wr) m_acc = r;
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_code = 0; src_sel = 0; src_word = 0; short_imm = 0;
    imm_byte = 0; prod_in = 0; acc_load = 0; load_val = 0;
  endtask

  task automatic do_op(logic [2:0] op, logic [3:0] s, logic [15:0] w,
                       logic sh, logic [7:0] imm, logic [31:0] p);
    @(negedge clk);
    op_valid = 1; op_code = op; src_sel = s; src_word = w;
    short_imm = sh; imm_byte = imm; prod_in = p;
    @(negedge clk);
    idle_inputs();
    model_op(op, s, w, sh, imm, p);
    check(op_req(op, sh, s), acc_out, m_acc);
    check("R6", {30'd0, flag_z, flag_n}, {30'd0, m_z, m_n});
  endtask

  task automatic do_load(logic [31:0] v);
    @(negedge clk);
    acc_load = 1; load_val = v;
    @(negedge clk);
    idle_inputs();
    m_acc = v;
    check("R10", acc_out, m_acc);
    check("R10", {30'd0, flag_z, flag_n}, {30'd0, m_z, m_n});
  endtask

  task automatic check_cond(logic [3:0] f, string req);
    cond_field = f;
    #1;
    check(req, {31'd0, cond_true}, {31'd0, cond_model(f, m_z, m_n)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    cond_field = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_acc = 0; m_z = 1; m_n = 0;
    // R11 reset state
    check("R11", acc_out, 32'h0);
    check("R11", {30'd0, flag_z, flag_n}, 32'd2);

    // R1 add / sub in the upper word, with wrap-around
    do_load(32'h0001_2345);
    do_op(3'd4, 4'd0, 16'h8000, 0, 8'h00, 32'h0);
    check("R1", acc_out, 32'h8001_2345);
    do_op(3'd1, 4'd5, 16'h8001, 0, 8'h00, 32'h0);
    check("R1", acc_out, 32'h0000_2345);
    do_op(3'd1, 4'd5, 16'h0001, 0, 8'h00, 32'h0);
    check("R6", {31'd0, flag_n}, 32'd1);

    // R3 logic ops leave the low word
    do_load(32'hF0F0_ABCD);
    do_op(3'd5, 4'd1, 16'h0FF0, 0, 8'h00, 32'h0);
    check("R3", acc_out, 32'h00F0_ABCD);
    do_op(3'd6, 4'd1, 16'h1200, 0, 8'h00, 32'h0);
    do_op(3'd7, 4'd1, 16'hFFFF, 0, 8'h00, 32'h0);

    // R2 full-width sources
    do_load(32'h1234_5678);
    do_op(3'd5, 4'd3, 16'h0000, 0, 8'h00, 32'h0);
    check("R2", acc_out, 32'h1234_5678);
    do_op(3'd4, 4'd11, 16'hFFFF, 0, 8'h00, 32'h0000_0008);
    check("R2", acc_out, 32'h1234_5680);
    do_op(3'd7, 4'd3, 16'h0000, 0, 8'h00, 32'h0);
    check("R2", acc_out, 32'h0);
    check("R6", {31'd0, flag_z}, 32'd1);

    // R4 compare
    do_load(32'h0005_0000);
    do_op(3'd3, 4'd0, 16'h0005, 0, 8'h00, 32'h0);
    check("R4", acc_out, 32'h0005_0000);
    check("R4", {31'd0, flag_z}, 32'd1);

    // R5 short immediate ignores the product index
    do_op(3'd4, 4'd11, 16'hAAAA, 1, 8'h81, 32'hFFFF_FFFF);
    check("R5", acc_out, 32'h0086_0000);

    // R7 reserved codes and idle
    do_op(3'd0, 4'd0, 16'h1111, 0, 8'h00, 32'h0);
    do_op(3'd2, 4'd0, 16'h1111, 0, 8'h00, 32'h0);
    @(negedge clk);
    check("R7", acc_out, m_acc);

    // R10 load wins over an op in the same cycle
    @(negedge clk);
    acc_load = 1; load_val = 32'hCAFE_0000;
    op_valid = 1; op_code = 3'd4; src_word = 16'h0001;
    @(negedge clk);
    idle_inputs();
    m_acc = 32'hCAFE_0000;
    check("R10", acc_out, m_acc);
    check("R10", {30'd0, flag_z, flag_n}, {30'd0, m_z, m_n});

    // R8 / R9 condition field
    for (int f = 0; f < 16; f++) check_cond(4'(f), (f % 8 == 0) ? "R8" : "R9");
    do_op(3'd7, 4'd3, 16'h0, 0, 8'h0, 32'h0);
    for (int f = 0; f < 16; f++) check_cond(4'(f), (f % 8 == 0) ? "R8" : "R9");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] s;
      case ($urandom % 4)
        0: s = 4'd3;
        1: s = 4'd11;
        default: s = 4'($urandom);
      endcase
      if ($urandom % 16 == 0) do_load($urandom);
      else do_op(3'($urandom), s, 16'($urandom), 1'($urandom % 3 == 0),
                 8'($urandom), $urandom);
      check_cond(4'($urandom), "R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule